// File: doc/BRIEF.md
# RGMII Receive Adapter

This block sits between the reduced-pin gigabit PHY receive pins and a MAC receive path. It is clocked by the receive clock that the PHY supplies. That clock runs at 125 MHz, 25 MHz or 2.5 MHz for 1000, 100 or 10 Mbit/s. The block samples four data lines and one control line on both edges of that clock. It turns them into a byte stream with a valid flag, an error flag and an alignment-error pulse. All outputs are registered in the receive-clock domain. There are no carrier-sense or collision pins on this interface, so the block recovers no half-duplex status.

The control line carries two flags. Its rising-edge sample is the data-valid flag. Its falling-edge sample is data-valid XOR receive-error, so the error flag is the XOR of the two samples. In gigabit mode one full byte arrives in every clock period. In 10/100 mode only the rising-edge nibble carries data. A two-state machine pairs consecutive nibbles, low nibble first, into one byte and strobes valid for one cycle.

The pairing machine has two states:
- PAIR_EVEN: no nibble is held.
- PAIR_ODD: a low nibble is held.

It has these transitions:
- HOLD_LOW: PAIR_EVEN to PAIR_ODD, in 10/100 mode with data-valid high.
- EMIT_BYTE: PAIR_ODD to PAIR_EVEN, with data-valid high.
- DROP_ODD: PAIR_ODD to PAIR_EVEN, with data-valid low. The partial byte is dropped and the alignment error pulses.
- FORCE_EVEN: from any state to PAIR_EVEN while gigabit mode is selected.

Frame parsing, CRC checking, preamble stripping and clock-domain crossing are left to downstream logic.

Top module: `rgmii_rx_adapter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, rx_byte is 0 and rx_valid, rx_err and rx_align_err are all 0.
- R2: With speed_gig=1, a byte whose low nibble is sampled on a rising edge and whose high nibble is sampled on the following falling edge appears on rx_byte (bits [3:0] rising, bits [7:4] falling) in the output register updated by the second rising edge after the first sample.
- R3: With speed_gig=1, rx_valid equals the rising-edge control sample, with the same latency as R2.
- R4: With speed_gig=1 and the byte valid, rx_err is the XOR of the rising-edge and falling-edge control samples.
- R5: Whenever rx_valid is 0, rx_byte is 0 and rx_err is 0. Falling-edge control activity with the rising-edge sample low produces no output.
- R6: With speed_gig=0, only rising-edge nibbles are used. Two consecutive valid nibbles form one byte, the first in bits [3:0] and the second in bits [7:4]. rx_valid is high for one cycle, in the output register updated by the second rising edge after the second nibble is sampled. Falling-edge data is ignored.
- R7: With speed_gig=0, rx_err on an emitted byte is 1 when either of its two nibbles had unequal rising- and falling-edge control samples.
- R8: With speed_gig=0, when data-valid falls after an odd number of nibbles, no byte is emitted and rx_align_err is high for exactly one cycle.
- R9: With speed_gig=0, rx_valid is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rxc | input | 1 | Receive clock from the PHY; both edges used |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_gig | input | 1 | 1 = gigabit (byte per period), 0 = 10/100 (nibble per period) |
| rgmii_rd | input | 4 | Receive data nibble |
| rgmii_rx_ctl | input | 1 | Receive control: valid on rising edge, valid XOR error on falling edge |
| rx_byte | output | 8 | Assembled receive byte, zero when not valid |
| rx_valid | output | 1 | Byte valid |
| rx_err | output | 1 | Receive error for the valid byte |
| rx_align_err | output | 1 | One-cycle pulse: frame ended on an odd nibble |

## Verification
Each gigabit byte reaches the outputs after the second rising edge after its low-nibble sample. The pairing state and the low nibble are registered once, so a 10/100 byte or an alignment pulse appears after the second rising edge after the nibble that completes or ends the pair. The bench keeps the previous cycle's drive pattern in a reference model. It drives new rising-edge values just before each rising edge. One time unit after that edge, it compares all four outputs with the model's result for the pattern from one period earlier. It then drives the falling-edge values. The checker properties look back two or three cycles with $past to tie the outputs to the control-pin history that produced them.

// File: rtl/rgrx_pkg.sv
package rgrx_pkg;
    typedef enum logic [0:0] {
        PAIR_EVEN = 1'b0,
        PAIR_ODD  = 1'b1
    } pair_state_e;
endpackage

// File: rtl/rgrx_ddr_capture.sv
// Double-edge sampler: one register set per clock edge.
module rgrx_ddr_capture #(
    parameter int NIB_W = 4
) (
    input  logic             rxc,
    input  logic             rst_n,
    input  logic [NIB_W-1:0] pin_d,
    input  logic             pin_ctl,
    output logic [NIB_W-1:0] rise_d,
    output logic             rise_ctl,
    output logic [NIB_W-1:0] fall_d,
    output logic             fall_ctl
);
    always_ff @(posedge rxc or negedge rst_n) begin
        if (!rst_n) begin
            rise_d   <= '0;
            rise_ctl <= 1'b0;
        end else begin
            rise_d   <= pin_d;
            rise_ctl <= pin_ctl;
        end
    end

    always_ff @(negedge rxc or negedge rst_n) begin
        if (!rst_n) begin
            fall_d   <= '0;
            fall_ctl <= 1'b0;
        end else begin
            fall_d   <= pin_d;
            fall_ctl <= pin_ctl;
        end
    end
endmodule

// File: rtl/rgrx_nibble_pair.sv
// Decodes valid/error and builds bytes in either speed mode.
module rgrx_nibble_pair
    import rgrx_pkg::*;
#(
    parameter int NIB_W = 4,
    localparam int BYTE_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              speed_gig,
    input  logic [NIB_W-1:0]  rise_d,
    input  logic              rise_ctl,
    input  logic [NIB_W-1:0]  fall_d,
    input  logic              fall_ctl,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_valid,
    output logic              out_err,
    output logic              out_align
);
    pair_state_e      state_q, state_d;
    logic [NIB_W-1:0] low_q;
    logic             eacc_q;
    logic             dv, er;

    logic [BYTE_W-1:0] byte_d;
    logic              valid_d, err_d, align_d;

    assign dv = rise_ctl;
    assign er = rise_ctl ^ fall_ctl;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (speed_gig) begin
            state_d = PAIR_EVEN;                        // FORCE_EVEN
        end else begin
            unique case (state_q)
                PAIR_EVEN: if (dv) state_d = PAIR_ODD;  // HOLD_LOW
                PAIR_ODD:  state_d = PAIR_EVEN;         // EMIT_BYTE / DROP_ODD
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PAIR_EVEN;
            low_q   <= '0;
            eacc_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (!speed_gig && state_q == PAIR_EVEN && dv) begin
                low_q  <= rise_d;
                eacc_q <= er;
            end
        end
    end

    // output decode
    always_comb begin
        byte_d  = '0;
        valid_d = 1'b0;
        err_d   = 1'b0;
        align_d = 1'b0;
        if (speed_gig) begin
            if (dv) begin
                byte_d  = {fall_d, rise_d};
                valid_d = 1'b1;
                err_d   = er;
            end
        end else begin
            unique case (state_q)
                PAIR_EVEN: ;
                PAIR_ODD: begin
                    if (dv) begin
                        byte_d  = {rise_d, low_q};
                        valid_d = 1'b1;
                        err_d   = eacc_q | er;
                    end else begin
                        align_d = 1'b1;
                    end
                end
            endcase
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_byte  <= '0;
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            out_align <= 1'b0;
        end else begin
            out_byte  <= byte_d;
            out_valid <= valid_d;
            out_err   <= err_d;
            out_align <= align_d;
        end
    end
endmodule

// File: rtl/rgmii_rx_adapter.sv
module rgmii_rx_adapter #(
    parameter int NIB_W = 4,
    localparam int BYTE_W = 2 * NIB_W
) (
    input  logic              rxc,
    input  logic              rst_n,
    input  logic              speed_gig,
    input  logic [NIB_W-1:0]  rgmii_rd,
    input  logic              rgmii_rx_ctl,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              rx_err,
    output logic              rx_align_err
);
    logic [NIB_W-1:0] rise_d, fall_d;
    logic             rise_ctl, fall_ctl;

    rgrx_ddr_capture #(.NIB_W(NIB_W)) u_cap (
        .rxc      (rxc),
        .rst_n    (rst_n),
        .pin_d    (rgmii_rd),
        .pin_ctl  (rgmii_rx_ctl),
        .rise_d   (rise_d),
        .rise_ctl (rise_ctl),
        .fall_d   (fall_d),
        .fall_ctl (fall_ctl)
    );

    rgrx_nibble_pair #(.NIB_W(NIB_W)) u_pair (
        .clk       (rxc),
        .rst_n     (rst_n),
        .speed_gig (speed_gig),
        .rise_d    (rise_d),
        .rise_ctl  (rise_ctl),
        .fall_d    (fall_d),
        .fall_ctl  (fall_ctl),
        .out_byte  (rx_byte),
        .out_valid (rx_valid),
        .out_err   (rx_err),
        .out_align (rx_align_err)
    );
endmodule

// File: rtl/rgrx_checker.sv
module rgrx_checker #(
    parameter int BYTE_W = 8
) (
    input logic              rxc,
    input logic              rst_n,
    input logic              speed_gig,
    input logic              rgmii_rx_ctl,
    input logic [BYTE_W-1:0] rx_byte,
    input logic              rx_valid,
    input logic              rx_err,
    input logic              rx_align_err
);
    // R5
    idle_zero_chk: assert property (@(posedge rxc) disable iff (!rst_n)
        !rx_valid |-> (rx_byte == '0 && !rx_err));

    // R3
    gig_valid_follows_ctl_chk: assert property (@(posedge rxc) disable iff (!rst_n)
        (speed_gig && $past(speed_gig) && $past(rst_n, 2))
        |-> (rx_valid == $past(rgmii_rx_ctl, 2)));

    // R6
    pair_needs_two_chk: assert property (@(posedge rxc) disable iff (!rst_n)
        (!$past(speed_gig) && !$past(speed_gig, 2) && $past(rst_n, 3) && rx_valid)
        |-> ($past(rgmii_rx_ctl, 2) && $past(rgmii_rx_ctl, 3)));

    // R8
    align_history_chk: assert property (@(posedge rxc) disable iff (!rst_n)
        (!$past(speed_gig) && !$past(speed_gig, 2) && $past(rst_n, 3) && rx_align_err)
        |-> (!$past(rgmii_rx_ctl, 2) && $past(rgmii_rx_ctl, 3)));

    // R8
    align_single_pulse_chk: assert property (@(posedge rxc) disable iff (!rst_n)
        rx_align_err |=> !rx_align_err);

    // R8
    align_no_valid_chk: assert property (@(posedge rxc) disable iff (!rst_n)
        rx_align_err |-> !rx_valid);

    // R9
    slow_valid_gap_chk: assert property (@(posedge rxc) disable iff (!rst_n)
        (!speed_gig && !$past(speed_gig) && rx_valid) |=> !rx_valid);
endmodule

bind rgmii_rx_adapter rgrx_checker #(.BYTE_W(BYTE_W)) u_chk (
    .rxc          (rxc),
    .rst_n        (rst_n),
    .speed_gig    (speed_gig),
    .rgmii_rx_ctl (rgmii_rx_ctl),
    .rx_byte      (rx_byte),
    .rx_valid     (rx_valid),
    .rx_err       (rx_err),
    .rx_align_err (rx_align_err)
);

// File: tb/sim_rgmii_rx_adapter.sv
`timescale 1ns/100ps
module sim_rgmii_rx_adapter;
    logic       rxc = 1'b0;
    logic       rst_n = 1'b0;
    logic       speed_gig = 1'b1;
    logic [3:0] rd = 4'h0;
    logic       ctl = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_valid, rx_err, rx_align_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference-model state
    logic       p_rc = 1'b0, p_fc = 1'b0;
    logic [3:0] p_rd = 4'h0, p_fd = 4'h0;
    logic [3:0] m_lo = 4'h0;
    bit         m_have = 1'b0;
    bit         m_eacc = 1'b0;
    bit         last_slow_valid = 1'b0;
    int unsigned lfsr = 32'h1234_5678;

    always #2 rxc = ~rxc;   // 250 MHz

    rgmii_rx_adapter u0 (
        .rxc(rxc), .rst_n(rst_n), .speed_gig(speed_gig),
        .rgmii_rd(rd), .rgmii_rx_ctl(ctl),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_err(rx_err),
        .rx_align_err(rx_align_err)
    );

    task automatic check_bit(input string req, input string what,
                             input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] rnd4();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr[3:0];
    endfunction

    // model of one processed sample (the previous cycle's drive pattern)
    task automatic compare_outputs();
        logic [7:0] e_byte = 8'h00;
        bit e_valid = 0, e_err = 0, e_align = 0;
        bit er = p_rc ^ p_fc;
        if (speed_gig) begin
            m_have = 0;
            if (p_rc) begin
                e_byte = {p_fd, p_rd}; e_valid = 1; e_err = er;
            end
        end else if (p_rc) begin
            if (!m_have) begin
                m_lo = p_rd; m_eacc = er; m_have = 1;
            end else begin
                e_byte = {p_rd, m_lo}; e_valid = 1; e_err = m_eacc | er; m_have = 0;
            end
        end else if (m_have) begin
            e_align = 1; m_have = 0;
        end
        if (!e_valid && !e_align) begin
            check_bit("R5", "idle byte", rx_byte, 8'h00);
            check_bit("R5", "idle valid", {7'b0, rx_valid}, 8'h00);
            check_bit("R5", "idle err", {7'b0, rx_err}, 8'h00);
        end else if (speed_gig) begin
            check_bit("R2", "gig byte", rx_byte, e_byte);
            check_bit("R3", "gig valid", {7'b0, rx_valid}, {7'b0, e_valid});
            check_bit("R4", "gig err", {7'b0, rx_err}, {7'b0, e_err});
        end else begin
            check_bit("R6", "slow byte", rx_byte, e_byte);
            check_bit("R6", "slow valid", {7'b0, rx_valid}, {7'b0, e_valid});
            check_bit("R7", "slow err", {7'b0, rx_err}, {7'b0, e_err});
        end
        check_bit("R8", "align", {7'b0, rx_align_err}, {7'b0, e_align});
        if (!speed_gig) begin
            // R9: no back-to-back valid at 10/100
            if (last_slow_valid) check_bit("R9", "valid gap", {7'b0, rx_valid}, 8'h00);
            last_slow_valid = rx_valid;
        end else begin
            last_slow_valid = 0;
        end
    endtask

    task automatic cycle(input logic rc, input logic [3:0] rdv,
                         input logic fc, input logic [3:0] fdv);
        @(negedge rxc); #1;
        ctl = rc; rd = rdv;
        @(posedge rxc); #1;
        compare_outputs();
        ctl = fc; rd = fdv;
        p_rc = rc; p_rd = rdv; p_fc = fc; p_fd = fdv;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 4'h0, 1'b0, 4'h0);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge rxc);
        #1;
        // R1: reset state
        check_bit("R1", "reset byte", rx_byte, 8'h00);
        check_bit("R1", "reset flags", {5'b0, rx_valid, rx_err, rx_align_err}, 8'h00);
        @(negedge rxc); rst_n = 1'b1;
        @(posedge rxc); #1;
        check_bit("R1", "first cycle flags", {5'b0, rx_valid, rx_err, rx_align_err}, 8'h00);

        // gigabit frame, clean bytes (R2, R3)
        speed_gig = 1'b1;
        idle(2);
        for (int i = 0; i < 8; i++) cycle(1'b1, rnd4(), 1'b1, rnd4());
        // gigabit error bytes (R4)
        cycle(1'b1, 4'hA, 1'b0, 4'h5);
        cycle(1'b1, 4'h3, 1'b1, 4'hC);
        idle(2);
        // falling-edge activity only (R5)
        for (int i = 0; i < 4; i++) cycle(1'b0, rnd4(), 1'b1, rnd4());
        idle(2);

        // 10/100 even frame with junk on falling data (R6, R9)
        speed_gig = 1'b0;
        idle(2);
        for (int i = 0; i < 8; i++) cycle(1'b1, rnd4(), 1'b1, rnd4());
        // error on the second nibble of a pair (R7)
        cycle(1'b1, 4'h1, 1'b1, 4'hF);
        cycle(1'b1, 4'h2, 1'b0, 4'hF);
        // error on the first nibble of a pair (R7)
        cycle(1'b1, 4'h7, 1'b0, 4'h0);
        cycle(1'b1, 4'h8, 1'b1, 4'h0);
        idle(3);
        // odd frame: five nibbles then end (R8)
        for (int i = 0; i < 5; i++) cycle(1'b1, rnd4(), 1'b1, rnd4());
        idle(3);
        // single nibble frame (R8)
        cycle(1'b1, 4'h9, 1'b1, 4'h0);
        idle(3);

        // random mixed traffic across both modes
        for (int k = 0; k < 400; k++) begin
            if ((k % 50) == 0) speed_gig = ~speed_gig;
            begin
                logic [3:0] a = rnd4();
                logic [3:0] b = rnd4();
                cycle(a[0] | a[1], b, a[2] ^ (a[0] | a[1]) ^ (a[3] & b[0]), rnd4());
            end
        end
        idle(4);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule